// File: doc/BRIEF.md
# Dual-Rail Regulator Soft-Start Sequencer

This block orders the power-up of a two-rail multiphase buck regulator. After reset it holds every output quiet until the supply-good input is high, then waits for a handshake saying the pin-strapped configuration has been captured. Only then does it park each rail's PWM output at the tri-state mid level, so that the external gate drivers see a defined idle code before any switching starts.

When the enable input rises, the sequencer raises the gate-driver enable. It then runs a digital reference code up from zero toward a boot target. Each step adds one or two LSBs, where one LSB is 5 mV, and one step is taken every `slew_div + 1` clock cycles. While the ramp runs, it tells the overvoltage logic to compare against the fixed absolute limit, so a pre-charged output does not trip it. Each rail leaves the mid level only when its own modulator reports a first pulse. The ready flag rises once the reference has settled at the target, which is the point at which commands can be accepted. A boot target of zero skips the ramp and leaves both rails idling at mid level. Dropping enable returns to mid level. Losing supply-good at any point drops everything back to the off state.

Top module: `vr_startup_seq`

## Requirements
- R1: While `supply_ok` is low, `drv_en`, `ready`, `ovp_abs_sel` are 0, `dac_code` is 0 and every rail's `pwm_lvl` field is 2'b00 (driven low).
- R2: After `supply_ok` rises, the PWM fields stay 2'b00 until `cfg_done` is seen high; after that every rail field reads 2'b01 (mid level) within two cycles.
- R3: With the sequencer idle at mid level, a high `enable` raises `drv_en` one clock later, and it stays high through the ramp and the ready phase.
- R4: During the ramp, `dac_code` (units of 5 mV) starts at 0 and grows by 1 (`step_wide`=0) or 2 (`step_wide`=1) every `slew_div`+1 cycles. The first increment lands `slew_div`+1 cycles after `drv_en` rises.
- R5: `dac_code` never exceeds the boot target; a final step that would overshoot it is clamped to the target exactly.
- R6: Rail n's field (bits 2n+1:2n) moves from 2'b01 to 2'b10 (released to the modulator) one clock after `first_pulse[n]` is high while the ramp or ready phase is active with a non-zero target; the other rails are unaffected.
- R7: `ready` rises one cycle after `dac_code` first equals the target and is never high while the code is still below it.
- R8: `ovp_abs_sel` is high exactly while the ramp is in progress.
- R9: Lowering `enable` clears `drv_en`, `ready` and `dac_code` and returns every released rail to 2'b01.
- R10: A boot target of 0 skips the ramp: `ready` and `drv_en` rise, `dac_code` stays 0 and rails stay at 2'b01 even when `first_pulse` fires.
- R11: Loss of `supply_ok` in any state clears `drv_en` and `ready` on the next clock, and the PWM fields and `dac_code` return to 0 on the clock after that.
- R12: `boot_code`, `step_wide` and `slew_div` are captured while idle; changes during a ramp do not alter its steps or its final code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good from undervoltage lockout |
| cfg_done | input | 1 | Configuration capture complete |
| enable | input | 1 | Regulator enable |
| boot_code | input | DAC_W (8) | Boot target in 5 mV LSBs |
| step_wide | input | 1 | 0: 1 LSB per step, 1: 2 LSB per step |
| slew_div | input | DIV_W (8) | Cycles per step minus one |
| first_pulse | input | RAILS (2) | Per-rail first modulator pulse |
| drv_en | output | 1 | Gate-driver enable |
| pwm_lvl | output | 2*RAILS (4) | Per-rail level: 00 low, 01 mid, 10 released |
| dac_code | output | DAC_W (8) | Reference code |
| ovp_abs_sel | output | 1 | Use absolute overvoltage threshold |
| ready | output | 1 | Can accept commands |

## Verification
A rail's first modulator pulse can arrive in the same cycle as the final reference step, and loss of supply-good can arrive in the same cycle as an increment of the ramp. The bench provokes the first case by pulsing a rail partway through a ramp and the other rail just as ready is reached. It provokes the second by dropping supply-good mid-ramp. The ramp length is judged against a bench function of target, step size and divider, sampled on every cycle, and the rail fields and driver enable are compared with the codes the requirements define.

// File: rtl/vr_seq_pkg.sv
// Shared types for the startup sequencer: sequence states and PWM level codes.
package vr_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_CFG  = 3'd1,
        ST_IDLE = 3'd2,
        ST_RAMP = 3'd3,
        ST_RDY  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        LVL_LOW = 2'b00,
        LVL_MID = 2'b01,
        LVL_RUN = 2'b10
    } pwm_lvl_e;
endpackage

// File: rtl/vr_seq_fsm.sv
// Sequence state machine: off -> config -> idle at mid -> ramp -> ready.
// Assumes all inputs are synchronous to clk; supply loss has top priority.
module vr_seq_fsm
    import vr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       cfg_done,
    input  logic       enable,
    input  logic       boot_zero,
    input  logic       at_tgt,
    output seq_state_e st_o
);
    seq_state_e st_q, st_d;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        if (!supply_ok) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF:  st_d = ST_CFG;
                ST_CFG:  if (cfg_done) st_d = ST_IDLE;
                ST_IDLE: if (enable) st_d = boot_zero ? ST_RDY : ST_RAMP;
                ST_RAMP: begin
                    if (!enable)     st_d = ST_IDLE;
                    else if (at_tgt) st_d = ST_RDY;
                end
                ST_RDY:  if (!enable) st_d = ST_IDLE;
                default: st_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    p_off_on_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> st_q == ST_OFF);
    p_idle_needs_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CFG && !cfg_done) |=> st_q != ST_IDLE);
endmodule

// File: rtl/vr_ramp_gen.sv
// Soft-start reference ramp: captures target, step size and divider while
// idle, then steps the code up by 1 or 2 LSB every div+1 cycles, clamped.
// Assumes load, run and hold are mutually exclusive.
module vr_ramp_gen #(
    parameter int DAC_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             hold,
    input  logic [DAC_W-1:0] tgt_in,
    input  logic             wide_in,
    input  logic [DIV_W-1:0] div_in,
    output logic [DAC_W-1:0] dac_o,
    output logic             at_tgt_o,
    output logic             tgt_zero_o
);
    localparam int SUM_W = DAC_W + 1;

    logic [DAC_W-1:0] tgt_q, dac_q, dac_nx;
    logic [DIV_W-1:0] div_q, cnt_q;
    logic             wide_q;
    logic [SUM_W-1:0] sum;

    // Clamped next code after one step.
    always_comb begin
        sum    = {1'b0, dac_q} + (wide_q ? SUM_W'(2) : SUM_W'(1));
        dac_nx = (sum >= {1'b0, tgt_q}) ? tgt_q : sum[DAC_W-1:0];
    end

    // Capture settings, run the prescaler and step the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            div_q  <= '0;
            wide_q <= 1'b0;
            cnt_q  <= '0;
            dac_q  <= '0;
        end else if (load) begin
            tgt_q  <= tgt_in;
            div_q  <= div_in;
            wide_q <= wide_in;
            cnt_q  <= '0;
            dac_q  <= '0;
        end else if (run) begin
            if (cnt_q == div_q) begin
                cnt_q <= '0;
                dac_q <= dac_nx;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (!hold) begin
            cnt_q <= '0;
            dac_q <= '0;
        end
    end

    assign dac_o      = dac_q;
    assign at_tgt_o   = (dac_q == tgt_q);
    assign tgt_zero_o = (tgt_q == '0);

    p_dac_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_q <= tgt_q);
    p_dac_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || dac_q >= $past(dac_q)));
    p_dac_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(tgt_q));
endmodule

// File: rtl/vr_rail_gate.sv
// One rail's PWM level: low while off/config, mid while idle, and handed to
// the modulator on the first pulse once releasing is allowed.
module vr_rail_gate
    import vr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e st,
    input  logic       release_en,
    input  logic       pulse,
    output pwm_lvl_e   lvl_o
);
    pwm_lvl_e lvl_q;

    // Level register driven by sequence state and first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            case (st)
                ST_IDLE: lvl_q <= LVL_MID;
                ST_RAMP, ST_RDY: begin
                    if (lvl_q == LVL_MID && release_en && pulse) lvl_q <= LVL_RUN;
                end
                default: lvl_q <= LVL_LOW;
            endcase
        end
    end

    assign lvl_o = lvl_q;

    p_run_needs_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != LVL_RUN) |=> (lvl_q != LVL_RUN || $past(pulse)));
    p_no_jump_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == LVL_LOW) |=> lvl_q != LVL_RUN);
endmodule

// File: rtl/vr_startup_seq.sv
// Startup and soft-start sequencer for a dual-rail multiphase regulator.
// Ties the state machine, reference ramp and per-rail PWM level gates.
// Assumes synchronous inputs; boot_code is in 5 mV LSBs.
module vr_startup_seq
    import vr_seq_pkg::*;
#(
    parameter int RAILS = 2,
    parameter int DAC_W = 8,
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_ok,
    input  logic               cfg_done,
    input  logic               enable,
    input  logic [DAC_W-1:0]   boot_code,
    input  logic               step_wide,
    input  logic [DIV_W-1:0]   slew_div,
    input  logic [RAILS-1:0]   first_pulse,
    output logic               drv_en,
    output logic [2*RAILS-1:0] pwm_lvl,
    output logic [DAC_W-1:0]   dac_code,
    output logic               ovp_abs_sel,
    output logic               ready
);
    seq_state_e st;
    logic       at_tgt, tgt_zero, release_en;

    vr_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .cfg_done  (cfg_done),
        .enable    (enable),
        .boot_zero (boot_code == '0),
        .at_tgt    (at_tgt),
        .st_o      (st)
    );

    vr_ramp_gen #(.DAC_W(DAC_W), .DIV_W(DIV_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (st == ST_IDLE),
        .run        (st == ST_RAMP),
        .hold       (st == ST_RDY),
        .tgt_in     (boot_code),
        .wide_in    (step_wide),
        .div_in     (slew_div),
        .dac_o      (dac_code),
        .at_tgt_o   (at_tgt),
        .tgt_zero_o (tgt_zero)
    );

    // Rails may leave mid level only while a real ramp runs or has finished.
    assign release_en = (st == ST_RAMP) || (st == ST_RDY && !tgt_zero);

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        pwm_lvl_e lvl;
        vr_rail_gate u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .st         (st),
            .release_en (release_en),
            .pulse      (first_pulse[r]),
            .lvl_o      (lvl)
        );
        assign pwm_lvl[2*r +: 2] = lvl;
    end

    assign drv_en      = (st == ST_RAMP) || (st == ST_RDY);
    assign ovp_abs_sel = (st == ST_RAMP);
    assign ready       = (st == ST_RDY);

    p_ready_at_tgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> at_tgt);
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!drv_en && !ready && !ovp_abs_sel));
    p_ovp_drv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_abs_sel |-> (drv_en && !ready));
endmodule

// File: tb/vr_startup_seq_tb_top.sv
`timescale 1ns/1ps
module vr_startup_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0, cfg_done = 1'b0, enable = 1'b0;
    logic [7:0] boot_code = '0;
    logic       step_wide = 1'b0;
    logic [7:0] slew_div = '0;
    logic [1:0] first_pulse = '0;
    logic       drv_en, ovp_abs_sel, ready;
    logic [3:0] pwm_lvl;
    logic [7:0] dac_code;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    vr_startup_seq dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cfg_done(cfg_done),
        .enable(enable), .boot_code(boot_code), .step_wide(step_wide),
        .slew_div(slew_div), .first_pulse(first_pulse), .drv_en(drv_en),
        .pwm_lvl(pwm_lvl), .dac_code(dac_code), .ovp_abs_sel(ovp_abs_sel),
        .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_k(input int tgt, input bit wide, input int div);
        int s = wide ? 2 : 1;
        int steps = (tgt + s - 1) / s;
        return steps * (div + 1) + 2;
    endfunction

    // Enable a ramp and follow it; returns the sample index at which ready showed.
    task automatic run_ramp(input int tgt, input bit wide, input int div, output int k);
        int prev, s;
        s = wide ? 2 : 1;
        enable = 1'b1;
        cyc(1);
        k = 1;
        chk(drv_en == 1'b1, "R3 drv_en on enable", drv_en, 1);
        prev = 0;
        while (!ready && k < 3000) begin
            chk(ovp_abs_sel == 1'b1, "R8 abs ovp during ramp", ovp_abs_sel, 1);
            chk(dac_code <= tgt, "R5 code within target", dac_code, tgt);
            chk(dac_code == prev || dac_code == prev + s || dac_code == tgt,
                "R4 step size", dac_code, prev + s);
            prev = dac_code;
            cyc(1);
            k++;
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k, t, d;
        bit w;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R1 quiet while supply is low
        chk(drv_en == 0 && ready == 0 && ovp_abs_sel == 0, "R1 outputs off", {drv_en, ready, ovp_abs_sel}, 0);
        chk(pwm_lvl == 4'b0000, "R1 pwm low", pwm_lvl, 0);
        chk(dac_code == 0, "R1 dac zero", dac_code, 0);
        // R2 no activity before configuration
        supply_ok = 1'b1;
        cyc(4);
        chk(pwm_lvl == 4'b0000, "R2 pwm low before cfg", pwm_lvl, 0);
        cfg_done = 1'b1;
        cyc(2);
        chk(pwm_lvl == 4'b0101, "R2 pwm mid after cfg", pwm_lvl, 5);

        // Random ramps: R4 R5 R7 R8 R9
        for (int i = 0; i < 10; i++) begin
            t = 1 + int'($urandom_range(0, 39));
            w = 1'($urandom_range(0, 1));
            d = int'($urandom_range(0, 5));
            boot_code = 8'(t); step_wide = w; slew_div = 8'(d);
            cyc(1);
            run_ramp(t, w, d, k);
            chk(k == exp_k(t, w, d), "R7 ready timing", k, exp_k(t, w, d));
            chk(dac_code == t, "R5 final code", dac_code, t);
            chk(ovp_abs_sel == 0 && drv_en == 1, "R8 abs ovp off at ready", ovp_abs_sel, 0);
            enable = 1'b0;
            cyc(2);
            chk(drv_en == 0 && ready == 0, "R9 disable clears", {drv_en, ready}, 0);
            chk(dac_code == 0, "R9 dac cleared", dac_code, 0);
            chk(pwm_lvl == 4'b0101, "R9 pwm mid", pwm_lvl, 5);
        end

        // R12 settings changed mid-ramp are ignored
        boot_code = 8'd10; step_wide = 1'b0; slew_div = 8'd1;
        cyc(1);
        fork
            run_ramp(10, 1'b0, 1, k);
            begin cyc(3); boot_code = 8'd50; step_wide = 1'b1; slew_div = 8'd0; end
        join
        chk(k == exp_k(10, 1'b0, 1), "R12 timing kept", k, exp_k(10, 1'b0, 1));
        chk(dac_code == 10, "R12 target kept", dac_code, 10);
        enable = 1'b0;
        cyc(2);

        // R6 rail-by-rail release, second rail on the ready cycle
        boot_code = 8'd30; step_wide = 1'b0; slew_div = 8'd3;
        cyc(1);
        enable = 1'b1;
        cyc(3);
        first_pulse = 2'b10;
        cyc(1);
        first_pulse = 2'b00;
        chk(pwm_lvl == 4'b1001, "R6 rail1 released only", pwm_lvl, 9);
        k = 0;
        while (!ready && k < 3000) begin cyc(1); k++; end
        first_pulse = 2'b01;
        cyc(1);
        first_pulse = 2'b00;
        chk(pwm_lvl == 4'b1010, "R6 rail0 released", pwm_lvl, 10);
        enable = 1'b0;
        cyc(2);
        chk(pwm_lvl == 4'b0101, "R9 released rails back to mid", pwm_lvl, 5);

        // R10 zero boot target
        boot_code = 8'd0;
        cyc(1);
        enable = 1'b1;
        cyc(2);
        chk(ready == 1 && drv_en == 1, "R10 ready without ramp", {ready, drv_en}, 3);
        chk(dac_code == 0 && ovp_abs_sel == 0, "R10 code zero", dac_code, 0);
        first_pulse = 2'b11;
        cyc(1);
        first_pulse = 2'b00;
        cyc(1);
        chk(pwm_lvl == 4'b0101, "R10 rails stay mid", pwm_lvl, 5);
        enable = 1'b0;
        cyc(2);

        // R11 supply loss during a ramp
        boot_code = 8'd40; step_wide = 1'b0; slew_div = 8'd2;
        cyc(1);
        enable = 1'b1;
        cyc(2);
        first_pulse = 2'b01;
        cyc(1);
        first_pulse = 2'b00;
        cyc(5);
        supply_ok = 1'b0;
        cyc(1);
        chk(drv_en == 0 && ready == 0, "R11 drv off next clock", {drv_en, ready}, 0);
        cyc(1);
        chk(pwm_lvl == 4'b0000, "R11 pwm low", pwm_lvl, 0);
        chk(dac_code == 0, "R11 dac cleared", dac_code, 0);
        cyc(2);
        chk(drv_en == 0, "R1 stays off with enable high", drv_en, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule